// File: doc/BRIEF.md
# Operating-Mode and Power Controller

This controller turns three slow level requests into the power enables of a stereo record/playback signal chain. The request bits ask for the analog pass-through switch, the record path and the playback path. The controller drives five signals: an enable for each of the three paths, a clock enable for the digital filters, and a reset pulse for those filters. It also raises an error flag. The request pins are asynchronous. They pass through a synchronizer and a stability filter before the controller acts on them.

A small state machine does the sequencing. It has three states:
- `ST_IDLE`: everything off, filter clock stopped.
- `ST_FRESET`: a filter reset sequence is running.
- `ST_RUN`: a valid non-idle mode is applied.

The transitions are:
- **idle-to-reset**: a record-bearing code is accepted while in `ST_IDLE`.
- **idle-to-run**: a non-idle code with no record bit is accepted while in `ST_IDLE`.
- **reset-to-run**: the reset count has expired.
- **run-to-run**: a new valid non-idle code is accepted in `ST_RUN`.
- **run-to-idle**: code 000 is accepted in `ST_RUN`.

Codes that combine pass-through with playback are reserved. When one is accepted, the controller keeps the mode it had and flags an error.

Top module: `mode_power_ctrl`

## Requirements
- R1: An asynchronous active-low reset forces all six outputs low at once, whether or not a clock edge occurs.
- R2: The request bit positions are [2] pass-through, [1] record, [0] playback. Each accepted valid code drives `thru_en_o`, `rec_en_o` and `play_en_o` equal to its bits [2], [1] and [0]. `filt_clk_en_o` is high exactly when record or playback is enabled.
- R3: The filter clock enable is low in the idle mode (000) and in the pass-through-only mode (100).
- R4: Accepting any code with bit [1] set while idle (010, 011 or 110) raises `filt_rst_o` for exactly RST_CYC (default 4) consecutive cycles. `filt_clk_en_o` rises in the same cycle as `filt_rst_o` and stays high throughout the pulse.
- R5: No filter reset pulse is produced for any other transition, such as idle to 001, 001 to 011, or 100 to 110.
- R6: Codes with bits [2] and [0] both set (101, 111) leave the applied mode unchanged and set `mode_err_o`. The next accepted valid code clears `mode_err_o`.
- R7: A request change must persist for STABLE_CYC (default 2) cycles to be accepted, so a one-cycle glitch has no effect. An accepted change appears at the outputs on the fourth rising edge after the request changes.
- R8: After reset is released, every enable stays low for at least the first two rising edges, whatever the request pins show.
- R9: A code accepted while a filter reset sequence runs is applied only after the sequence ends, and the pulse still lasts RST_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_i | input | 3 | Asynchronous request: [2] pass-through, [1] record, [0] playback |
| rec_en_o | output | 1 | Record path power enable |
| play_en_o | output | 1 | Playback path power enable |
| thru_en_o | output | 1 | Analog pass-through switch enable |
| filt_clk_en_o | output | 1 | Digital filter clock enable |
| filt_rst_o | output | 1 | Digital filter reset pulse |
| mode_err_o | output | 1 | Reserved code seen; last valid mode retained |

## Verification
The bench measures the length of every filter reset pulse and checks that the filter clock is enabled in each pulse cycle. A controller that fires the pulse on the wrong transition, such as playback to record-and-playback or pass-through to record-with-pass-through, is caught by a nonzero pulse count. A controller that resets with its clock gated is also caught. Reserved codes are sent from a running mode: a design that decodes them would switch on playback beside pass-through or drop record, and one that forgets to clear the flag keeps the error high. A one-cycle glitch, a request issued right at reset release, a code change in the middle of a reset pulse and an asynchronous reset between edges probe the synchronizer, the stability filter, the deferral rule and the reset path.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef struct packed {
        logic thru;
        logic rec;
        logic play;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FRESET = 2'd1,
        ST_RUN    = 2'd2
    } state_t;

    function automatic logic is_reserved(input mode_t m);
        return m.thru & m.play;
    endfunction

endpackage

// File: rtl/mpc_sync.sv
module mpc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d_i};
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mpc_stable.sv
module mpc_stable #(
    parameter int W          = 3,
    parameter int STABLE_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    output logic         acc_vld_o,
    output logic [W-1:0] acc_code_o
);
    localparam int CW  = $clog2(STABLE_CYC + 1);
    localparam int LIM = STABLE_CYC - 2;

    logic [W-1:0]  hold_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            cnt_q  <= '0;
        end else if (sync_i != hold_q) begin
            hold_q <= sync_i;
            cnt_q  <= '0;
        end else if (cnt_q != CW'(LIM)) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign acc_vld_o  = (sync_i == hold_q) && (cnt_q == CW'(LIM));
    assign acc_code_o = hold_q;

    // R7: an accepted code was present on the synchronized input one cycle earlier too
    assert_accept_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld_o |-> (sync_i == $past(sync_i)));
endmodule

// File: rtl/mpc_fsm.sv
module mpc_fsm
    import mpc_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  acc_vld_i,
    input  mode_t acc_code_i,
    output logic  rec_en_o,
    output logic  play_en_o,
    output logic  thru_en_o,
    output logic  filt_clk_en_o,
    output logic  filt_rst_o,
    output logic  mode_err_o
);
    localparam int CW = $clog2(RST_CYC + 1);

    state_t        state_q, state_d;
    mode_t         mode_q, mode_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          take;

    assign take = acc_vld_i && !is_reserved(acc_code_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && (acc_code_i != mode_t'(3'b000))) begin
                    mode_d = acc_code_i;
                    if (acc_code_i.rec) begin
                        state_d = ST_FRESET;
                        cnt_d   = CW'(RST_CYC - 1);
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_FRESET: begin
                if (cnt_q == '0) state_d = ST_RUN;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_RUN: begin
                if (take) begin
                    mode_d = acc_code_i;
                    if (acc_code_i == mode_t'(3'b000)) state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                mode_d  = '0;
            end
        endcase
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_en_o      <= 1'b0;
            play_en_o     <= 1'b0;
            thru_en_o     <= 1'b0;
            filt_clk_en_o <= 1'b0;
            filt_rst_o    <= 1'b0;
            mode_err_o    <= 1'b0;
        end else begin
            rec_en_o      <= mode_d.rec;
            play_en_o     <= mode_d.play;
            thru_en_o     <= mode_d.thru;
            filt_clk_en_o <= mode_d.rec | mode_d.play;
            filt_rst_o    <= (state_d == ST_FRESET);
            if (acc_vld_i) mode_err_o <= is_reserved(acc_code_i);
        end
    end

    // checker state
    logic [1:0]    boot_q;
    logic [CW-1:0] plen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_q <= '0;
            plen_q <= '0;
        end else begin
            if (boot_q != 2'd2) boot_q <= boot_q + 1'b1;
            plen_q <= filt_rst_o ? plen_q + 1'b1 : '0;
        end
    end

    // R3: filter clock gated while idle
    assert_idle_clk_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !filt_clk_en_o);

    // R3: pass-through only keeps the filter clock stopped
    assert_thru_only_clk_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (thru_en_o && !rec_en_o && !play_en_o) |-> !filt_clk_en_o);

    // R4: filters are clocked during their reset
    assert_rst_with_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rst_o |-> (filt_clk_en_o && rec_en_o));

    // R4: pulse length
    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filt_rst_o) |-> (plen_q == CW'(RST_CYC)));

    assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rst_o |-> (plen_q < CW'(RST_CYC)));

    // R5: a reset pulse starts only out of the idle state
    assert_rst_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_rst_o) |-> $past(state_q == ST_IDLE));

    // R6: reserved combination never reaches the enables
    assert_no_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(thru_en_o && play_en_o));

    // R8: idle held right after reset release
    assert_boot_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q != 2'd2) |-> !(rec_en_o || play_en_o || thru_en_o));
endmodule

// File: rtl/mode_power_ctrl.sv
module mode_power_ctrl
    import mpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 2,
    parameter int RST_CYC     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_req_i,
    output logic       rec_en_o,
    output logic       play_en_o,
    output logic       thru_en_o,
    output logic       filt_clk_en_o,
    output logic       filt_rst_o,
    output logic       mode_err_o
);
    localparam int MW = $bits(mode_t);

    logic [MW-1:0] req_sync;
    logic [MW-1:0] acc_code;
    logic          acc_vld;

    mpc_sync #(.W(MW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (mode_req_i),
        .q_o   (req_sync)
    );

    mpc_stable #(.W(MW), .STABLE_CYC(STABLE_CYC)) u_stable (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (req_sync),
        .acc_vld_o  (acc_vld),
        .acc_code_o (acc_code)
    );

    mpc_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_vld_i     (acc_vld),
        .acc_code_i    (mode_t'(acc_code)),
        .rec_en_o      (rec_en_o),
        .play_en_o     (play_en_o),
        .thru_en_o     (thru_en_o),
        .filt_clk_en_o (filt_clk_en_o),
        .filt_rst_o    (filt_rst_o),
        .mode_err_o    (mode_err_o)
    );
endmodule

// File: tb/mode_power_ctrl_tb.sv
module mode_power_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req = 3'b000;
    logic       rec_en, play_en, thru_en, filt_clk_en, filt_rst, mode_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mode_power_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_req_i    (req),
        .rec_en_o      (rec_en),
        .play_en_o     (play_en),
        .thru_en_o     (thru_en),
        .filt_clk_en_o (filt_clk_en),
        .filt_rst_o    (filt_rst),
        .mode_err_o    (mode_err)
    );

    // order: thru, rec, play, filter clock, filter reset, error
    function automatic logic [5:0] outs();
        return {thru_en, rec_en, play_en, filt_clk_en, filt_rst, mode_err};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] c);
        @(negedge clk);
        req = c;
    endtask

    task automatic watch(input int n, output int pl, output int bad);
        pl  = 0;
        bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (filt_rst) pl++;
            if (filt_rst && !filt_clk_en) bad++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        req   = 3'b000;
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", outs(), 0);
    endtask

    task automatic t_power_on_record();
        int pl, bad;
        @(negedge clk);
        rst_n = 1'b1;
        req   = 3'b010;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8 idle after release", outs(), 0);
        watch(12, pl, bad);
        check("R4 pulse length idle->010", pl, 4);
        check("R4 clock during reset", bad, 0);
        check("R2 record only enables", outs(), 6'b010100);
    endtask

    task automatic t_record_to_idle();
        int pl, bad;
        apply(3'b000);
        watch(8, pl, bad);
        check("R3 idle all off", outs(), 0);
    endtask

    task automatic t_idle_to_play();
        int pl, bad;
        apply(3'b001);
        repeat (4) @(negedge clk);
        check("R7 latency play_en", play_en, 1);
        watch(8, pl, bad);
        check("R5 no pulse idle->001", pl, 0);
        check("R2 playback only enables", outs(), 6'b001100);
    endtask

    task automatic t_glitch();
        int diff = 0;
        @(negedge clk);
        req = 3'b000;
        @(negedge clk);
        req = 3'b001;
        repeat (10) begin
            @(negedge clk);
            if (outs() != 6'b001100) diff++;
        end
        check("R7 one-cycle glitch ignored", diff, 0);
    endtask

    task automatic t_play_to_both();
        int pl, bad;
        apply(3'b011);
        watch(10, pl, bad);
        check("R5 no pulse 001->011", pl, 0);
        check("R2 record+playback enables", outs(), 6'b011100);
    endtask

    task automatic t_idle_to_both();
        int pl, bad;
        apply(3'b000);
        watch(8, pl, bad);
        apply(3'b011);
        watch(12, pl, bad);
        check("R4 pulse length idle->011", pl, 4);
        check("R4 clock during reset 011", bad, 0);
    endtask

    task automatic t_defer();
        int pl1, pl2, bad;
        apply(3'b000);
        watch(8, pl1, bad);
        apply(3'b010);
        watch(3, pl1, bad);
        req = 3'b011;
        watch(12, pl2, bad);
        check("R9 pulse kept during change", pl1 + pl2, 4);
        check("R9 deferred code applied", outs(), 6'b011100);
    endtask

    task automatic t_thru();
        int pl, bad;
        apply(3'b000);
        watch(8, pl, bad);
        apply(3'b100);
        watch(10, pl, bad);
        check("R5 no pulse idle->100", pl, 0);
        check("R3 pass-through only clock off", outs(), 6'b100000);
        apply(3'b110);
        watch(10, pl, bad);
        check("R5 no pulse 100->110", pl, 0);
        check("R2 record+pass enables", outs(), 6'b110100);
    endtask

    task automatic t_idle_to_rec_thru();
        int pl, bad;
        apply(3'b000);
        watch(8, pl, bad);
        apply(3'b110);
        watch(12, pl, bad);
        check("R4 pulse length idle->110", pl, 4);
    endtask

    task automatic t_reserved();
        int pl, bad;
        apply(3'b101);
        watch(10, pl, bad);
        check("R6 101 keeps mode, flags", outs(), 6'b110101);
        apply(3'b111);
        watch(10, pl, bad);
        check("R6 111 keeps mode, flags", outs(), 6'b110101);
        apply(3'b010);
        watch(10, pl, bad);
        check("R6 valid code clears flag", outs(), 6'b010100);
    endtask

    task automatic t_async_reset();
        int pl, bad;
        @(negedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        check("R1 async reset between edges", outs(), 0);
        @(negedge clk);
        req   = 3'b000;
        rst_n = 1'b1;
        watch(6, pl, bad);
        check("R1 idle after async reset", outs(), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        t_reset();
        t_power_on_record();
        t_record_to_idle();
        t_idle_to_play();
        t_glitch();
        t_play_to_both();
        t_idle_to_both();
        t_defer();
        t_thru();
        t_idle_to_rec_thru();
        t_reserved();
        t_async_reset();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule